// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable cycle model of a small pipelined burst SRAM with a 32-bit word made of four byte lanes. A new access starts when one of two address strobes is taken with the address bus valid. One strobe belongs to the processor and the other to the controller. The address is registered. Its two lowest bits seed a 2-bit burst counter, and an advance input steps that counter through an aligned group of four words. Three chip enables decide whether the model is selected. They are looked at only when a new address is loaded.

Each rising edge carries out one access at the address that edge makes effective. A read returns its word right after that edge. A write applies the byte mask built from a global write control or from a byte-write enable and per-byte selects. Read data is qualified by a valid flag rather than by a tri-state bus. The flag is gated by an asynchronous output enable. It is also suppressed on the first read after the model leaves the deselected state. A sleep input freezes every register and the memory contents.

Top module: `burstSramModel`

## Requirements
- R1: While rstN is low and after its release, the model is deselected, rdValid is 0 and rdData is 0 until a selected read completes.
- R2: A taken strobe captures addrIn. Its bits [1:0] seed the burst counter, so the access of that edge uses addrIn unchanged.
- R3: When procStrobeN and ctrlStrobeN are both low and selANegN is low, only the processor strobe counts. A processor-strobe load is always a read, and the write controls are ignored on that edge.
- R4: While selANegN is high, procStrobeN has no effect. The address register, counter and select state keep their values.
- R5: The model is selected when selANegN=0, selBPos=1 and selCNegN=0. These three are evaluated only on edges that load an address. On other edges the previous select state stays.
- R6: With advanceN low on a selected edge that loads nothing, the counter increments linearly and wraps modulo 4 within the aligned four-word group, while address bits [5:2] stay fixed. With advanceN high, the same word is accessed again.
- R7: globalWrN low on a selected, non-processor-load edge writes all four bytes, whatever byteWrEnN and byteSelN are.
- R8: With globalWrN high and byteWrEnN low, byte b (wrData[8b+7:8b]) is written only if byteSelN[b] is low. With both high, the edge is a read even if byteSelN is low.
- R9: A read word appears on rdData with rdValid high right after the edge that accessed it. Write and deselected edges leave rdValid at 0.
- R10: rdValid and rdData are 0 whenever outEnN is high. They are also 0 for the first read edge that follows a deselected state, whatever outEnN is.
- R11: While sleep is high, no register or memory word changes and rdValid is 0. The first edge with sleep low acts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | Word address |
| procStrobeN | input | 1 | Processor address strobe, active low, higher priority |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| selANegN | input | 1 | Chip enable A, active low; also gates the processor strobe |
| selBPos | input | 1 | Chip enable B, active high |
| selCNegN | input | 1 | Chip enable C, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write-all-bytes control, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| byteSelN | input | 4 | Per-byte write selects, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze input, active high |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, 0 when not valid |
| rdValid | output | 1 | Read data qualifier |

## Verification
A wrong counter or a wrong address register shows up at the next read as a word from the wrong slot of the four-word group. A wrong select latch or a wrong strobe priority shows up as a valid flag that appears or goes missing on the very next edge. The bench writes four known words, then reads them back through wraps, suspends, strobe conflicts and deselects. Every edge is compared, so a fault is reported within one cycle of the edge where it first reaches rdData or rdValid. Byte-mask and sleep faults stay hidden until the affected word is read back. The bench does that read within three edges.

// File: rtl/burstSramPkg.sv
package burstSramPkg;
  localparam int NUM_BYTES = 4;
  localparam int DATA_W = 8 * NUM_BYTES;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic hold;
    logic load;
    logic advance;
    logic readEn;
    logic [NUM_BYTES-1:0] wrMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/burstCounter.sv
module burstCounter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] seed,
  output logic [W-1:0] countNext
);
  logic [W-1:0] count;

  always_comb begin
    if (load) countNext = seed;
    else if (advance) countNext = count + W'(1);
    else countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (!hold) count <= countNext;
  end

  // R6
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hold && advance && !load) |=> (count == $past(count) + W'(1)));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hold && load) |=> (count == $past(seed)));
endmodule

// File: rtl/burstSramControl.sv
module burstSramControl
  import burstSramPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 selANegN,
  input  logic                 selBPos,
  input  logic                 selCNegN,
  input  logic                 advanceN,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 outEnN,
  input  logic                 sleep,
  output ctrlStrobes_t         strobes,
  output logic                 rdValidOut
);
  logic selReg, validReg, firstReg;
  logic enablesOn, procTake, ctrlTake, loadNow, selNext, wrCycle;

  always_comb begin
    enablesOn = !selANegN && selBPos && !selCNegN;
    procTake  = !procStrobeN && !selANegN;
    ctrlTake  = !ctrlStrobeN && !procTake;
    loadNow   = procTake || ctrlTake;
    selNext   = loadNow ? enablesOn : selReg;
    wrCycle   = selNext && !procTake && (!globalWrN || !byteWrEnN);

    strobes.hold    = sleep;
    strobes.load    = loadNow;
    strobes.advance = !loadNow && !advanceN && selNext;
    strobes.readEn  = selNext && !wrCycle;
    if (!wrCycle) strobes.wrMask = '0;
    else if (!globalWrN) strobes.wrMask = '1;
    else strobes.wrMask = ~byteSelN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= 1'b0;
      validReg <= 1'b0;
      firstReg <= 1'b0;
    end else if (!sleep) begin
      selReg   <= selNext;
      validReg <= strobes.readEn;
      firstReg <= strobes.readEn && !selReg;
    end
  end

  assign rdValidOut = validReg && !firstReg && !outEnN && !sleep;

  // R5
  enables_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && procStrobeN && ctrlStrobeN) |=> $stable(selReg));

  // R10
  first_read_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && strobes.readEn && !selReg) |=> !rdValidOut);

  // R3
  proc_is_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !procStrobeN && !selANegN && selBPos && !selCNegN) |=> validReg);

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(selReg) && $stable(validReg) && $stable(firstReg)));
endmodule

// File: rtl/burstSramDatapath.sv
module burstSramDatapath
  import burstSramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord
);
  localparam int WORDS   = 1 << ADDR_W;
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [UPPER_W-1:0] upperReg, upperNext;
  logic [BURST_W-1:0] burstNext;
  logic [ADDR_W-1:0]  opAddr;
  logic [DATA_W-1:0]  laneRead;

  burstCounter #(.W(BURST_W)) u_counter (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (strobes.hold),
    .load     (strobes.load),
    .advance  (strobes.advance),
    .seed     (addrIn[BURST_W-1:0]),
    .countNext(burstNext)
  );

  always_comb begin
    upperNext = strobes.load ? addrIn[ADDR_W-1:BURST_W] : upperReg;
    opAddr    = {upperNext, burstNext};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upperReg <= '0;
    else if (!strobes.hold) upperReg <= upperNext;
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic [7:0] laneMem [WORDS];
    always_ff @(posedge clk) begin
      if (!strobes.hold && strobes.wrMask[b]) laneMem[opAddr] <= wrData[b*8 +: 8];
    end
    assign laneRead[b*8 +: 8] = laneMem[opAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdWord <= '0;
    else if (!strobes.hold && strobes.readEn) rdWord <= laneRead;
  end

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.hold && !strobes.load) |=> $stable(upperReg));

  // R11
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> ($stable(rdWord) && $stable(upperReg)));
endmodule

// File: rtl/burstSramModel.sv
module burstSramModel
  import burstSramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              selANegN,
  input  logic              selBPos,
  input  logic              selCNegN,
  input  logic              advanceN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [3:0]        byteSelN,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rdValid
);
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] rdWord;
  logic validOut;

  burstSramControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .selANegN   (selANegN),
    .selBPos    (selBPos),
    .selCNegN   (selCNegN),
    .advanceN   (advanceN),
    .globalWrN  (globalWrN),
    .byteWrEnN  (byteWrEnN),
    .byteSelN   (byteSelN),
    .outEnN     (outEnN),
    .sleep      (sleep),
    .strobes    (strobes),
    .rdValidOut (validOut)
  );

  burstSramDatapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .addrIn (addrIn),
    .wrData (wrData),
    .rdWord (rdWord)
  );

  assign rdValid = validOut;
  assign rdData  = validOut ? rdWord : '0;

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!rdValid && rdData == '0));
endmodule

// File: tb/burstSramModel_tb.sv
module burstSramModel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] addrIn = '0;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1;
  logic selANegN = 1'b1, selBPos = 1'b0, selCNegN = 1'b1;
  logic advanceN = 1'b1, globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [3:0] byteSelN = 4'hF;
  logic outEnN = 1'b0, sleep = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rdValid;

  int checks = 0;
  int fails = 0;
  logic expVq [$];
  logic [31:0] expDq [$];
  string tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burstSramModel u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .selANegN(selANegN), .selBPos(selBPos), .selCNegN(selCNegN),
    .advanceN(advanceN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .byteSelN(byteSelN), .outEnN(outEnN), .sleep(sleep),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic checkNow(input logic expV, input logic [31:0] expD, input string tag);
    checks++;
    if (rdValid !== expV || rdData !== expD) begin
      fails++;
      $display("FAIL %s: rdValid=%0b rdData=%h expected rdValid=%0b rdData=%h",
               tag, rdValid, rdData, expV, expD);
    end
  endtask

  // monitor: compare results just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expVq.size() > 0) checkNow(expVq.pop_front(), expDq.pop_front(), tagQ.pop_front());
    end
  end

  // driver: set inputs at the falling edge, queue the expected result of the next edge
  task automatic step(input logic pN, input logic cN, input logic [2:0] ce,
                      input logic advN, input logic gwN, input logic bweN,
                      input logic [3:0] bsN, input logic oeN, input logic slp,
                      input logic [5:0] a, input logic [31:0] wd,
                      input logic expV, input logic [31:0] expD, input string tag);
    @(negedge clk);
    procStrobeN = pN; ctrlStrobeN = cN;
    selANegN = ce[2]; selBPos = ce[1]; selCNegN = ce[0];
    advanceN = advN; globalWrN = gwN; byteWrEnN = bweN; byteSelN = bsN;
    outEnN = oeN; sleep = slp; addrIn = a; wrData = wd;
    expVq.push_back(expV); expDq.push_back(expD); tagQ.push_back(tag);
  endtask

  localparam logic [2:0] CE_ON  = 3'b010;
  localparam logic [2:0] CE_B0  = 3'b000;
  localparam logic [2:0] CE_AHI = 3'b110;

  initial begin
    repeat (200) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkNow(1'b0, 32'h0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkNow(1'b0, 32'h0, "R1 after reset");
    // R7: global write fills 8..11; byte controls inactive
    step(1,0,CE_ON, 1,0,1,4'hF,0,0, 6'd8, 32'hA0A0A0A0, 0,32'h0, "R7 write 8");
    step(1,1,CE_ON, 0,0,1,4'hF,0,0, 6'd0, 32'hA1A1A1A1, 0,32'h0, "R7 write 9");
    step(1,1,CE_ON, 0,0,1,4'hF,0,0, 6'd0, 32'hA2A2A2A2, 0,32'h0, "R7 write 10");
    step(1,1,CE_ON, 0,0,1,4'hF,0,0, 6'd0, 32'hA3A3A3A3, 0,32'h0, "R7 write 11");
    // R2 R9: processor load reads 8 right after edge
    step(0,1,CE_ON, 1,1,1,4'hF,0,0, 6'd8, 32'h0, 1,32'hA0A0A0A0, "R2 load read 8");
    // R6 linear burst and wrap
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA1A1A1A1, "R6 burst 9");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA2A2A2A2, "R6 burst 10");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA3A3A3A3, "R6 burst 11");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA0A0A0A0, "R6 wrap to 8");
    step(1,1,CE_ON, 1,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA0A0A0A0, "R6 suspend 8");
    // R10: output enable high
    step(1,1,CE_ON, 1,1,1,4'hF,1,0, 6'd0, 32'h0, 0,32'h0, "R10 oe high");
    // R8: byte write of lanes 0 and 2 into 9
    step(1,0,CE_ON, 1,1,0,4'b1010,0,0, 6'd9, 32'h11223344, 0,32'h0, "R8 byte write");
    step(1,0,CE_ON, 1,1,1,4'h0,0,0, 6'd10, 32'hFFFFFFFF, 1,32'hA2A2A2A2, "R8 no enable read");
    step(0,1,CE_ON, 1,1,1,4'hF,0,0, 6'd9, 32'h0, 1,32'hA122A144, "R8 lanes merged");
    // R3: both strobes, processor wins, write ignored
    step(0,0,CE_ON, 1,0,1,4'hF,0,0, 6'd11, 32'hDEAD0000, 1,32'hA3A3A3A3, "R3 both strobes");
    step(0,1,CE_ON, 1,1,1,4'hF,0,0, 6'd11, 32'h0, 1,32'hA3A3A3A3, "R3 word unchanged");
    // R4: processor strobe with enable A high does nothing
    step(0,1,CE_AHI, 1,1,1,4'hF,0,0, 6'd8, 32'h0, 1,32'hA3A3A3A3, "R4 proc ignored");
    // R5: enables ignored without load, counter wraps 11 to 8
    step(1,1,CE_B0, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA0A0A0A0, "R5 enables held");
    step(1,0,CE_B0, 1,1,1,4'hF,0,0, 6'd8, 32'h0, 0,32'h0, "R5 deselect load");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 0,32'h0, "R5 stays deselected");
    // R10: first read after deselect masked
    step(0,1,CE_ON, 1,1,1,4'hF,0,0, 6'd8, 32'h0, 0,32'h0, "R10 first read masked");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA122A144, "R10 second read");
    // R11: sleep blocks a write and freezes the counter
    step(1,0,CE_ON, 0,0,1,4'hF,0,1, 6'd10, 32'h0, 0,32'h0, "R11 sleeping");
    step(1,1,CE_ON, 1,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA122A144, "R11 counter held");
    step(1,1,CE_ON, 0,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA2A2A2A2, "R11 write blocked");
    step(1,1,CE_ON, 1,1,1,4'hF,0,0, 6'd0, 32'h0, 1,32'hA2A2A2A2, "R9 repeat read");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule